// File: doc/BRIEF.md
# Event-Handshake Serial Shift Pipeline

A chain of single-bit storage stages that moves data without any shared shift enable. Each stage owns a small join element with two event inputs. One is a "ready" event from the stage below, meaning that stage is empty. The other is an "acknowledge" event from the stage above, meaning a fresh bit has been placed here. The stage fires once both events have been recorded, in either order or in the same cycle. Firing moves the stored bit one stage downstream and sends an acknowledge event to that stage. After a fixed number of cycles it also sends a ready event back upstream. Every event is a one-cycle pulse on the single fast clock that drives the block.

The input end connects to a bit source. The source places a bit with a strobe and is told by a request pulse when another bit may come. The output end releases one bit for each ready pulse applied there. A mode pin, sampled only while reset is high, selects the initial arming. In shift mode the chain starts full of zeros with every stage already acknowledged. In load mode the chain starts empty and ready, so the first bits travel to the far end and park there. A busy flag reports handshake events still travelling through the chain.

Top module: `hs_shift_pipe`

## Requirements
- R1: While reset is high and in the first cycle after it, `out_stb`, `in_req` and `busy` are 0 and `out_bit` is 0, in either mode.
- R2: In load mode (`mode_shift`=0 during reset) on an empty chain, the first bit offered parks in the last stage. Filling all STAGES stages produces no `out_stb` and exactly STAGES-1 `in_req` pulses. The bit that fills stage 0 produces no request.
- R3: A stage fires when its ready and acknowledge events have both arrived, whichever comes first or when they coincide. If the last stage's acknowledge becomes visible in cycle a and a second `tail_send` is applied in cycle s, the second `out_stb` is seen in cycle max(s, a)+1.
- R4: Each firing of the last stage gives exactly one `out_stb`, one cycle after the `tail_send` that completed it, with `out_bit` holding the bit that left. Bits leave in the order they entered.
- R5: With a full chain, a `tail_send` in cycle c gives `in_req` first in cycle c + STAGES*SEND_DLY and not before.
- R6: Two `tail_send` pulses that both arrive before the last stage is re-acknowledged count as one. They produce a single extra `out_stb`.
- R7: In shift mode (`mode_shift`=1 during reset), the chain behaves as full of zeros with all stages acknowledged. While the source refills after every request, the output stream is STAGES zeros followed by the offered bits in order, and every `tail_send` yields one `in_req`.
- R8: A stage never receives a new bit while it still holds an acknowledged one. Stored bits are never lost, duplicated or altered in transit, for every 4-bit fill pattern.
- R9: `busy` is 1 from the cycle after a shift starts until the cycle that shows its `in_req`. It returns to 0 in the cycle after that. An `in_req` always follows a cycle with `busy` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast event clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_shift | input | 1 | Initial arming during reset: 1 shift (full), 0 load (empty) |
| in_bit | input | 1 | Bit offered by the source |
| in_stb | input | 1 | One-cycle pulse placing `in_bit` into stage 0 |
| in_req | output | 1 | One-cycle ready event to the source |
| tail_send | input | 1 | One-cycle ready event at the output end |
| out_bit | output | 1 | Last bit released, held until the next release |
| out_stb | output | 1 | One-cycle pulse marking a released bit |
| busy | output | 1 | Handshake events still travelling in the chain |

## Verification
If a join element holds a wrong state, the next `tail_send` shows it at the ports. Either no `out_stb` appears, or a second one appears, or `in_req` comes in a cycle other than STAGES*SEND_DLY after it, or `busy` stays high. So a single shift exposes it within about STAGES*SEND_DLY+1 cycles. A corrupted stored bit shows up only when that bit reaches the output. That takes up to STAGES more shifts, so every fill pattern is drained completely. Arrival order at the join is swept by moving the second ready pulse across every cycle around the acknowledge arrival.

// File: rtl/hs_shift_pipe.sv
module hs_shift_pipe #(
  parameter int STAGES   = 4,
  parameter int SEND_DLY = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic mode_shift,
  input  logic in_bit,
  input  logic in_stb,
  output logic in_req,
  input  logic tail_send,
  output logic out_bit,
  output logic out_stb,
  output logic busy
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] rdy_seen, ack_seen, rdy_ev, ack_ev, fire;
  logic [LAST:0] slot, slot_nxt, take, src;
  logic [LAST:0] ack_q, rdy_back, in_flight;
  logic          in_ack;

  assign rdy_ev = {tail_send, rdy_back[LAST:1]};
  assign ack_ev = {ack_q[LAST-1:0], in_ack};
  assign fire   = (rdy_seen | rdy_ev) & (ack_seen | ack_ev);

  assign take     = {fire[LAST-1:0], in_stb};
  assign src      = {slot[LAST-1:0], in_bit};
  assign slot_nxt = (take & src) | (~take & ~fire & slot);

  assign in_req = rdy_back[0];
  assign busy   = (|in_flight) | (|ack_q) | in_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_seen <= mode_shift ? '0 : {1'b0, {LAST{1'b1}}};
      ack_seen <= mode_shift ? '1 : '0;
      slot     <= '0;
      ack_q    <= '0;
      in_ack   <= 1'b0;
      out_bit  <= 1'b0;
      out_stb  <= 1'b0;
    end else begin
      rdy_seen <= (rdy_seen | rdy_ev) & ~fire;
      ack_seen <= (ack_seen | ack_ev) & ~fire;
      slot     <= slot_nxt;
      ack_q    <= fire;
      in_ack   <= in_stb;
      out_stb  <= fire[LAST];
      if (fire[LAST]) out_bit <= slot[LAST];
    end
  end

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [SEND_DLY-1:0] line;
    if (SEND_DLY == 1) begin : g_short
      always_ff @(posedge clk)
        if (rst) line <= '0;
        else     line <= fire[g];
    end else begin : g_long
      always_ff @(posedge clk)
        if (rst) line <= '0;
        else     line <= {line[SEND_DLY-2:0], fire[g]};
    end
    assign rdy_back[g]  = line[SEND_DLY-1];
    assign in_flight[g] = |line;

    if (g > 0) begin : g_chk
      a_r8_receiver_empty: assert property (@(posedge clk) disable iff (rst)
        fire[g-1] |-> !ack_seen[g]);
    end
  end

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!out_stb && !in_req && !busy));

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    out_stb |=> !out_stb);

  a_r4_tail_was_armed: assert property (@(posedge clk) disable iff (rst)
    out_stb |-> $past(ack_seen[LAST] | ack_q[LAST-1]));

  a_r9_req_after_busy: assert property (@(posedge clk) disable iff (rst)
    in_req |-> $past(busy));
endmodule

// File: tb/tb_hs_shift_pipe.sv
module tb_hs_shift_pipe;
  localparam int N = 4;
  localparam int D = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_shift = 1'b0;
  logic in_bit = 1'b0, in_stb = 1'b0, tail_send = 1'b0;
  logic in_req, out_bit, out_stb, busy;

  int tests = 0, fails = 0;
  int ocnt = 0, rcnt = 0;
  logic obits [0:255];

  always #10 clk = ~clk;

  hs_shift_pipe #(.STAGES(N), .SEND_DLY(D)) dut (
    .clk(clk), .rst(rst), .mode_shift(mode_shift), .in_bit(in_bit),
    .in_stb(in_stb), .in_req(in_req), .tail_send(tail_send),
    .out_bit(out_bit), .out_stb(out_stb), .busy(busy));

  always @(posedge clk) if (!rst) begin
    if (out_stb) begin
      if (ocnt < 256) obits[ocnt] = out_bit;
      ocnt++;
    end
    if (in_req) rcnt++;
  end

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic m);
    @(negedge clk);
    rst = 1'b1; mode_shift = m; tail_send = 1'b0; in_stb = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_idle();
    repeat (2) @(negedge clk);
    for (int k = 0; k < 200 && busy; k++) @(negedge clk);
  endtask

  task automatic push(input logic b);
    in_bit = b; in_stb = 1'b1;
    @(negedge clk);
    in_stb = 1'b0;
    wait_idle();
  endtask

  task automatic shift_once();
    tail_send = 1'b1;
    @(negedge clk);
    tail_send = 1'b0;
    wait_idle();
  endtask

  task automatic fill(input logic [N-1:0] p);
    for (int i = 0; i < N; i++) push(p[i]);
  endtask

  initial begin
    #(20ns * 150000);
    fails++; tests++;
    $display("FAIL R4 watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int o0, r0, second;
    logic [9:0] stream;

    // R1: reset state, both modes
    for (int m = 0; m < 2; m++) begin
      do_reset(m[0]);
      check("R1 out_stb", out_stb, 0);
      check("R1 in_req", in_req, 0);
      check("R1 busy", busy, 0);
      check("R1 out_bit", out_bit, 0);
    end

    // R2 R4 R8: exhaustive fill/drain in load mode
    for (int p = 0; p < 16; p++) begin
      do_reset(1'b0);
      o0 = ocnt; r0 = rcnt;
      fill(p[N-1:0]);
      check("R2 no output while filling", ocnt - o0, 0);
      check("R2 requests during fill", rcnt - r0, N - 1);
      for (int i = 0; i < N; i++) shift_once();
      check("R4 one output per send", ocnt - o0, N);
      for (int i = 0; i < N; i++)
        check("R8 R4 bit order", obits[o0 + i], p[i]);
    end

    // R4 R5 R9: cycle timing of one shift on a full chain
    do_reset(1'b0);
    fill(4'b0110);
    tail_send = 1'b1;
    @(negedge clk);
    tail_send = 1'b0;
    check("R4 out_stb one cycle later", out_stb, 1);
    check("R4 out_bit", out_bit, 0);
    check("R9 busy during shift", busy, 1);
    for (int k = 2; k <= N * D + 1; k++) begin
      @(negedge clk);
      if (k < N * D) check("R5 no early in_req", in_req, 0);
      if (k == N * D) begin
        check("R5 in_req cycle", in_req, 1);
        check("R9 busy at request", busy, 1);
      end
      if (k == N * D + 1) check("R9 busy drops", busy, 0);
    end

    // R3: sweep second send across the acknowledge arrival
    for (int s = 1; s <= D + 4; s++) begin
      do_reset(1'b0);
      fill(4'b0110);
      o0 = ocnt;
      second = -1;
      for (int k = 0; k < 24; k++) begin
        if (k > 0) @(negedge clk);
        if (out_stb && k > 1 && second < 0) second = k;
        tail_send = (k == 0 || k == s);
      end
      tail_send = 1'b0;
      wait_idle();
      check("R3 second release cycle", second, ((s > D + 1) ? s : D + 1) + 1);
      check("R3 second bit", obits[o0 + 1], 1);
    end

    // R6: two early sends collapse to one
    do_reset(1'b0);
    fill(4'b1011);
    o0 = ocnt;
    for (int k = 0; k < 30; k++) begin
      if (k > 0) @(negedge clk);
      tail_send = (k == 0 || k == 1 || k == 2);
    end
    tail_send = 1'b0;
    wait_idle();
    check("R6 absorbed duplicate send", ocnt - o0, 2);

    // R7: shift mode stream with refill after every request
    do_reset(1'b1);
    stream = 10'b1101001011;
    o0 = ocnt;
    for (int k = 0; k < 10; k++) begin
      r0 = rcnt;
      shift_once();
      check("R7 request per shift", rcnt - r0, 1);
      push(stream[k]);
    end
    check("R7 output count", ocnt - o0, 10);
    for (int j = 0; j < 10; j++)
      check("R7 stream value", obits[o0 + j], (j < N) ? 0 : int'(stream[j - N]));

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule